// File: doc/BRIEF.md
# Fractional-N Modulus Accumulator

This block lets a frequency synthesiser reach channels between the steps of its comparison frequency. On each comparison cycle, marked by a strobe from the main divider's end-of-sequence pulse, it adds a programmed fractional numerator to a small running total. The total wraps at a modulus chosen at runtime: 5 gives steps of one fifth of the comparison frequency, and 8 gives steps of one eighth. Each wrap raises a one-cycle overflow flag. The modulus-control logic uses that flag to move exactly one prescaler cycle from the low division ratio to the high one.

Once fractional operation is enabled it runs continuously. A new channel word restarts the total from zero, and so does disabling the function. A numerator of zero never wraps, so the loop then behaves as a plain integer divider.

Top module: `fracacc_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `overflowPulse` is 0 and the running total is 0.
- R2: With `modeEighths` = 1 and the block enabled, each `cycleStrobe` adds `numerator` (0..7) to the total. When the sum is 8 or more, the total becomes sum − 8 and `overflowPulse` is 1 in the cycle after the strobe edge.
- R3: A numerator of 0 never produces an overflow, in either modulus.
- R4: With `modeEighths` = 0 the modulus is 5. A sum of 5 or more wraps to sum − 5 and produces one overflow, so the total stays in 0..4.
- R5: With `modeEighths` = 0, numerator codes 5, 6 and 7 act as 4.
- R6: `overflowPulse` rises only in the cycle after an edge at which `cycleStrobe` was high with the block enabled and no channel load, and it lasts one clock per wrap.
- R7: Without `cycleStrobe`, the total holds and no overflow is produced.
- R8: While `fracEnable` is 0, the total is cleared and `overflowPulse` stays 0.
- R9: `channelLoad` clears the total. It takes priority over a strobe in the same cycle, which then adds nothing and produces no overflow.
- R10: Over P strobes after a clear, the number of overflows equals floor(P·n/M), where n is the effective numerator and M the modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycleStrobe | input | 1 | One-cycle comparison-cycle marker |
| numerator | input | 3 | Fractional numerator |
| modeEighths | input | 1 | 1 selects modulus 8, 0 selects modulus 5 |
| fracEnable | input | 1 | Enables fractional operation |
| channelLoad | input | 1 | A new channel word is being latched |
| overflowPulse | output | 1 | One-cycle overflow flag towards modulus control |

## Verification
The bench targets the edges of the wrap comparison. A total that lands exactly on 5 or 8 must wrap; a design using a strict greater-than test would hold one step too long and miss an overflow. Numerator codes 5 to 7 in fifths mode are checked, since a missing clamp would overflow too often. A strobe arriving in the same cycle as a channel load or a disable is also checked; a design that gets this priority wrong keeps a stale total and yields a wrong fraction. Long random runs compare every cycle against a reference total, which exposes a wrong wrap amount or a pulse that lasts longer than one clock.

// File: rtl/fracacc_pkg.sv
package fracacc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;       // zero the running total
    logic advance;     // add numerator this cycle
    logic useEighths;  // modulus select
  } accCtrl_t;
endpackage

// File: rtl/fracacc_ctrl.sv
module fracacc_ctrl
  import fracacc_pkg::*;
(
  input  logic     cycleStrobe,
  input  logic     modeEighths,
  input  logic     fracEnable,
  input  logic     channelLoad,
  output accCtrl_t ctrl
);
  always_comb begin
    ctrl.clear      = !fracEnable || channelLoad;   // R8, R9: clear wins
    ctrl.advance    = cycleStrobe && fracEnable && !channelLoad;
    ctrl.useEighths = modeEighths;
  end
endmodule

// File: rtl/fracacc_dp.sv
module fracacc_dp
  import fracacc_pkg::*;
#(
  parameter int NUM_W  = 3,
  parameter int MOD_LO = 5,
  parameter int MOD_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  accCtrl_t         ctrl,
  input  logic [NUM_W-1:0] numerator,
  output logic [$clog2(MOD_HI)-1:0] accValue,
  output logic             overflowPulse
);
  localparam int ACC_W = $clog2(MOD_HI);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [NUM_W-1:0] CLAMP_LO = NUM_W'(MOD_LO - 1);
  localparam logic [SUM_W-1:0] MOD_LO_S = SUM_W'(MOD_LO);
  localparam logic [SUM_W-1:0] MOD_HI_S = SUM_W'(MOD_HI);

  logic [NUM_W-1:0] effNum;
  logic [SUM_W-1:0] modVal, sumVal, wrapVal;
  logic             wraps;

  always_comb begin
    // R5: clamp numerator in the shorter modulus
    effNum  = (!ctrl.useEighths && numerator > CLAMP_LO) ? CLAMP_LO : numerator;
    modVal  = ctrl.useEighths ? MOD_HI_S : MOD_LO_S;
    sumVal  = SUM_W'(accValue) + SUM_W'(effNum);
    wraps   = sumVal >= modVal;
    wrapVal = sumVal - modVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accValue      <= '0;
      overflowPulse <= 1'b0;
    end else if (ctrl.clear) begin
      accValue      <= '0;
      overflowPulse <= 1'b0;
    end else if (ctrl.advance) begin
      accValue      <= wraps ? ACC_W'(wrapVal) : ACC_W'(sumVal);
      overflowPulse <= wraps;
    end else begin
      overflowPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/fracacc_top.sv
module fracacc_top
  import fracacc_pkg::*;
#(
  parameter int NUM_W  = 3,
  parameter int MOD_LO = 5,
  parameter int MOD_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycleStrobe,
  input  logic [NUM_W-1:0] numerator,
  input  logic             modeEighths,
  input  logic             fracEnable,
  input  logic             channelLoad,
  output logic             overflowPulse
);
  localparam int ACC_W = $clog2(MOD_HI);

  accCtrl_t         ctrl;
  logic [ACC_W-1:0] accValue;

  fracacc_ctrl ctrl_i (
    .cycleStrobe (cycleStrobe),
    .modeEighths (modeEighths),
    .fracEnable  (fracEnable),
    .channelLoad (channelLoad),
    .ctrl        (ctrl)
  );

  fracacc_dp #(.NUM_W(NUM_W), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI)) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl          (ctrl),
    .numerator     (numerator),
    .accValue      (accValue),
    .overflowPulse (overflowPulse)
  );
endmodule

// File: rtl/fracacc_checker.sv
module fracacc_checker #(
  parameter int NUM_W  = 3,
  parameter int MOD_LO = 5,
  parameter int MOD_HI = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cycleStrobe,
  input logic [NUM_W-1:0]          numerator,
  input logic                      modeEighths,
  input logic                      fracEnable,
  input logic                      channelLoad,
  input logic                      overflowPulse,
  input logic [$clog2(MOD_HI)-1:0] accValue
);
  localparam int ACC_W = $clog2(MOD_HI);
  localparam logic [ACC_W-1:0] LO_LIM = ACC_W'(MOD_LO);

  assert_pulse_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflowPulse) |-> $past(cycleStrobe && fracEnable && !channelLoad));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleStrobe && fracEnable && !channelLoad && numerator == '0) |=> !overflowPulse);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycleStrobe && fracEnable && !channelLoad) |=> ($stable(accValue) && !overflowPulse));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fracEnable |=> (accValue == '0 && !overflowPulse));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    channelLoad |=> (accValue == '0 && !overflowPulse));

  assert_fifths_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleStrobe && fracEnable && !channelLoad && !modeEighths && accValue < LO_LIM)
      |=> accValue < LO_LIM);
endmodule

bind fracacc_top fracacc_checker #(.NUM_W(NUM_W), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cycleStrobe   (cycleStrobe),
  .numerator     (numerator),
  .modeEighths   (modeEighths),
  .fracEnable    (fracEnable),
  .channelLoad   (channelLoad),
  .overflowPulse (overflowPulse),
  .accValue      (accValue)
);

// File: tb/fracacc_top_tb_top.sv
`timescale 1ns/100ps
module fracacc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic [2:0] numerator = '0;
  logic       modeEighths = 1'b0;
  logic       fracEnable = 1'b0;
  logic       channelLoad = 1'b0;
  logic       overflowPulse;

  int checks = 0;
  int fails = 0;
  int refAcc = 0;
  int ovCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fracacc_top dut_i (
    .clk(clk), .rst_n(rst_n), .cycleStrobe(cycleStrobe), .numerator(numerator),
    .modeEighths(modeEighths), .fracEnable(fracEnable), .channelLoad(channelLoad),
    .overflowPulse(overflowPulse)
  );

  function automatic int effNum(input int n, input bit eighths);
    return (!eighths && n > 4) ? 4 : n;
  endfunction

  function automatic int modOf(input bit eighths);
    return eighths ? 8 : 5;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive, advance reference, compare flag after the edge
  task automatic step(input bit stb, input int n, input bit m8, input bit en,
                      input bit ld, input string req);
    int expOv;
    @(negedge clk);
    cycleStrobe = stb; numerator = 3'(n); modeEighths = m8;
    fracEnable = en; channelLoad = ld;
    @(posedge clk);
    expOv = 0;
    if (!en || ld) refAcc = 0;
    else if (stb) begin
      refAcc += effNum(n, m8);
      if (refAcc >= modOf(m8)) begin
        refAcc -= modOf(m8);
        expOv = 1;
      end
    end
    #1;
    if (overflowPulse) ovCount++;
    check(req, int'(overflowPulse), expOv);
  endtask

  // R10: count overflows over P strobes from a cleared total
  task automatic runCount(input int n, input bit m8, input int p, input string req);
    step(1'b0, n, m8, 1'b1, 1'b1, req);
    ovCount = 0;
    for (int i = 0; i < p; i++) begin
      step(1'b1, n, m8, 1'b1, 1'b0, req);
      step(1'b0, n, m8, 1'b1, 1'b0, req);
    end
    check(req, ovCount, (p * effNum(n, m8)) / modOf(m8));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(overflowPulse), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1", int'(overflowPulse), 0);

    // R1: first strobe after reset sees total 0 (3 + 0 < 8)
    step(1'b1, 3, 1'b1, 1'b1, 1'b0, "R1");
    step(1'b0, 3, 1'b1, 1'b1, 1'b1, "R1");

    runCount(3, 1'b1, 16, "R2");
    runCount(7, 1'b1, 9, "R2");
    runCount(1, 1'b1, 8, "R2");     // exact landing on 8 must wrap
    runCount(0, 1'b1, 12, "R3");
    runCount(0, 1'b0, 12, "R3");
    runCount(2, 1'b0, 10, "R4");
    runCount(1, 1'b0, 5, "R4");     // exact landing on 5 must wrap
    runCount(6, 1'b0, 10, "R5");
    runCount(7, 1'b0, 7, "R5");
    runCount(5, 1'b0, 6, "R5");

    // R6: back-to-back strobes, then a gap: pulse lasts one clock
    step(1'b0, 4, 1'b1, 1'b1, 1'b1, "R6");
    step(1'b1, 4, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 4, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b0, 4, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b0, 4, 1'b1, 1'b1, 1'b0, "R6");

    // R7: total held across idle cycles, then one strobe completes a wrap
    step(1'b0, 6, 1'b1, 1'b1, 1'b1, "R7");
    step(1'b1, 6, 1'b1, 1'b1, 1'b0, "R7");
    repeat (5) step(1'b0, 6, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 2, 1'b1, 1'b1, 1'b0, "R7");

    // R8: strobes while disabled do nothing; total restarts from 0
    step(1'b1, 6, 1'b1, 1'b1, 1'b0, "R8");
    repeat (4) step(1'b1, 7, 1'b1, 1'b0, 1'b0, "R8");
    step(1'b1, 1, 1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1, 1'b1, 1'b1, 1'b0, "R8");

    // R9: load with a strobe in the same cycle adds nothing
    step(1'b1, 7, 1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 7, 1'b1, 1'b1, 1'b1, "R9");
    step(1'b1, 1, 1'b1, 1'b1, 1'b0, "R9");

    // Random mix, mode changes only with a load or disable
    begin
      bit m8 = 1'b1;
      bit en = 1'b1;
      int n = 3;
      for (int i = 0; i < 4000; i++) begin
        bit ld = ($urandom_range(0, 40) == 0);
        bit stb = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 80) == 0) en = ~en;
        if (ld || !en) begin
          m8 = 1'($urandom_range(0, 1));
          n = $urandom_range(0, 7);
        end
        step(stb, n, m8, en, ld, "R10");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule